// File: doc/BRIEF.md
# I2C Transmit Descriptor Sequencer

This block drives the transmit side of an I2C master from a ring of buffer descriptors kept in a small local memory. A pulse on the trigger input sends it around the ring. For each descriptor it reads the control word, the byte count and a 32-bit byte pointer. It then fetches the payload bytes one by one and hands the byte-level bus engine a series of commands: start condition, byte write and stop condition. When a buffer is finished, it writes a status word back into the descriptor, which returns ownership to software.

Bits in each descriptor's control word select the following:
- whether the buffer opens with a start condition;
- whether it closes with a stop condition;
- whether the walk returns to the ring base after this entry;
- whether an event is raised when the entry is done.

The bus engine answers every command with a response code. A not-acknowledged byte, lost arbitration or a data underrun ends the buffer, is recorded in the descriptor, and halts the ring until the next trigger.

Top module: `i2c_txbd_seq`

## Requirements
- R1: A descriptor takes four consecutive 16-bit words at word offsets 0 to 3: the control word, the byte count, the pointer's upper half and the pointer's lower half. Consecutive ring entries are 4 words apart. Memory reads return data on the cycle after `mem_rd`. A read and a write are never issued in the same cycle.
- R2: The trigger `go` is accepted only while `busy` is low. Control bits are numbered with bit 0 as the word's MSB, so control bit k is `mem_rdata[15-k]`. If a fetched control word has its ready bit (bit 0, `[15]`) clear, the block returns to idle. In that case it issues no command and no memory write. While idle, no memory or command request is active.
- R3: The first descriptor after a trigger is always preceded by a start command. Every later descriptor gets a start command only if its start bit (bit 5, `[10]`) is set.
- R4: Commands are encoded on `cmd_op` as 0 for start, 1 for byte write and 2 for stop. The payload bytes go out as write commands in increasing address order. The byte at byte address a is taken from memory word a>>1: the high half when a is even, the low half when a is odd.
- R5: A buffer whose last bit (bit 4, `[11]`) is set ends with a stop command after its final byte. A buffer with that bit clear gets no stop command.
- R6: A descriptor with a byte count of zero issues no write command. It still receives start and stop commands according to R3 and R5 and is written back as completed.
- R7: When a buffer ends, the control word is rewritten with the ready bit cleared and all reserved bits (bits 1 and 6 to 12) zero. The wrap, interrupt, last and start bits are kept. The status bits NAK (bit 13, `[2]`), underrun (bit 14, `[1]`) and collision (bit 15, `[0]`) reflect the outcome.
- R8: After a descriptor completes without error, the next descriptor is read from `ring_base` if its wrap bit (bit 2, `[13]`) is set. Otherwise it is read from the current address plus 4.
- R9: The response code is interpreted as follows: 0 means success, 1 sets NAK, 2 sets collision and 3 sets underrun. A nonzero code ends the buffer at once, with no further commands and no stop. After the write-back the block goes idle until a new trigger.
- R10: When a descriptor whose interrupt bit (bit 3, `[12]`) is set is written back, one of the following is pulsed for one cycle, together with that write:
  - `ev_txb` if the buffer completed without error;
  - `ev_txe` if it ended with an error.

  Neither event is raised when the bit is clear.
- R11: A command stays valid with stable `cmd_op` and `cmd_byte` until it is accepted. After acceptance no new command is offered until `rsp_valid` has returned its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start trigger for the ring walk |
| ring_base | input | AW | Word address of the first ring entry |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Write data (descriptor write-back) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 start, 1 write byte, 2 stop |
| cmd_byte | output | 8 | Byte to write |
| rsp_valid | input | 1 | Byte engine response strobe |
| rsp_code | input | 2 | 0 ok, 1 no acknowledge, 2 arbitration lost, 3 underrun |
| ev_txb | output | 1 | Buffer-done event |
| ev_txe | output | 1 | Buffer-error event |
| busy | output | 1 | Ring walk in progress |

## Verification
The assertions check the per-cycle rules on every cycle:
- the command stays stable while it is offered, and only one command is in flight;
- nothing is requested while idle, and reads never coincide with writes;
- the written-back word has reserved bits zero and the ready bit clear;
- each event coincides with a write-back whose status matches it;
- an error write-back is followed by idle.

The bench scenarios cover the rest: the exact sequence of start, byte and stop commands, the byte ordering, the wrap back to the ring base, the forced start on the first entry, and the stopping point of the ring after an error at a chosen command. For these, the bench compares the command log and the memory image against a model that walks the same ring independently.

// File: rtl/i2c_txbd_seq.sv
module i2c_txbd_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] ring_base,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_code,
  output logic          ev_txb,
  output logic          ev_txe,
  output logic          busy
);
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_STOP = 2'd2;
  localparam logic [1:0] RC_NAK = 2'd1, RC_CL = 2'd2, RC_UN = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_C, S_L, S_PH, S_PL, S_PL2, S_DRD, S_DCAP, S_CMD, S_RSP, S_WB
  } st_t;

  st_t         st;
  logic [AW-1:0] dp;
  logic        first;
  logic [15:0] ctrl, len, bhi, cnt;
  logic [31:0] bp;
  logic [1:0]  op, err;
  logic [7:0]  byt;
  logic [31:0] baddr;

  assign baddr = bp + {16'd0, cnt};
  assign busy  = (st != S_IDLE);

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = dp;
    case (st)
      S_C:   mem_rd = 1'b1;
      S_L:   begin mem_rd = mem_rdata[15]; mem_addr = dp + AW'(1); end
      S_PH:  begin mem_rd = 1'b1; mem_addr = dp + AW'(2); end
      S_PL:  begin mem_rd = 1'b1; mem_addr = dp + AW'(3); end
      S_DRD: begin mem_rd = (cnt != len); mem_addr = baddr[AW:1]; end
      default: ;
    endcase
  end

  assign mem_wr    = (st == S_WB);
  assign mem_wdata = {2'b00, ctrl[13:10], 7'd0, err == RC_NAK, err == RC_UN, err == RC_CL};
  assign ev_txb    = mem_wr && ctrl[12] && (err == 2'd0);
  assign ev_txe    = mem_wr && ctrl[12] && (err != 2'd0);
  assign cmd_valid = (st == S_CMD);
  assign cmd_op    = op;
  assign cmd_byte  = byt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dp <= '0; first <= 1'b0; ctrl <= '0; len <= '0;
      bhi <= '0; bp <= '0; cnt <= '0; op <= OP_START; err <= '0; byt <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin dp <= ring_base; first <= 1'b1; st <= S_C; end
        S_C:    st <= S_L;
        S_L:    begin ctrl <= mem_rdata; st <= mem_rdata[15] ? S_PH : S_IDLE; end
        S_PH:   begin len <= mem_rdata; st <= S_PL; end
        S_PL:   begin bhi <= mem_rdata; st <= S_PL2; end
        S_PL2: begin
          bp <= {bhi, mem_rdata}; cnt <= '0; err <= '0;
          if (first || ctrl[10]) begin op <= OP_START; st <= S_CMD; end
          else st <= S_DRD;
        end
        S_DRD:
          if (cnt != len) st <= S_DCAP;
          else if (ctrl[11]) begin op <= OP_STOP; st <= S_CMD; end
          else st <= S_WB;
        S_DCAP: begin
          byt <= baddr[0] ? mem_rdata[7:0] : mem_rdata[15:8];
          op  <= OP_WR;
          st  <= S_CMD;
        end
        S_CMD: if (cmd_ready) st <= S_RSP;
        S_RSP:
          if (rsp_valid) begin
            if (rsp_code != 2'd0) begin err <= rsp_code; st <= S_WB; end
            else if (op == OP_STOP) st <= S_WB;
            else begin
              if (op == OP_WR) cnt <= cnt + 16'd1;
              st <= S_DRD;
            end
          end
        S_WB: begin
          first <= 1'b0;
          if (err != 2'd0) st <= S_IDLE;
          else begin
            dp <= ctrl[13] ? ring_base : dp + AW'(4);
            st <= S_C;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_txbd_seq_chk.sv
module i2c_txbd_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [15:0]   mem_wdata,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_byte,
  input logic          ev_txb,
  input logic          ev_txe,
  input logic          busy
);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  p_one_inflight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cmd_valid || mem_rd || mem_wr));
  p_no_rw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_wb_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata[15:14] == 2'b00) && (mem_wdata[9:3] == 7'd0));
  p_ev_with_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txb || ev_txe) |-> mem_wr && !(ev_txb && ev_txe));
  p_ev_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txe |-> mem_wdata[2:0] != 3'd0) and (ev_txb |-> mem_wdata[2:0] == 3'd0));
  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && (mem_wdata[2:0] != 3'd0) |=> !busy);
endmodule

bind i2c_txbd_seq i2c_txbd_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_i2c_txbd_seq.sv
module sim_i2c_txbd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic [15:0] mem_rdata = '0;
  logic cmd_ready = 1'b0, rsp_valid = 1'b0;
  logic [1:0] rsp_code = '0;
  logic mem_rd, mem_wr, cmd_valid, ev_txb, ev_txe, busy;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  i2c_txbd_seq #(.AW(AW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [4096];
  logic [15:0] exp_mem [4096];
  int log_op [256], log_b [256], nlog;
  int e_op [256], e_b [256], ne;
  int nwr, nwatch, watch, ntxb, ntxe, etxb, etxe;
  int err_at = -1, err_c = 0, ncmd;
  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; nwr <= nwr + 1; end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr];
      if (int'(mem_addr) == watch) nwatch <= nwatch + 1;
    end
  end

  initial begin : engine
    int pend, dly, pcode;
    pend = 0; dly = 0; pcode = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend != 0 && dly == 0) begin rsp_valid = 1'b1; rsp_code = 2'(pcode); pend = 0; end
      else if (pend != 0) dly--;
      if (ev_txb) ntxb++;
      if (ev_txe) ntxe++;
      cmd_ready = ($urandom % 3) != 0;
      if (cmd_valid && cmd_ready) begin
        if (nlog < 256) begin log_op[nlog] = int'(cmd_op); log_b[nlog] = int'(cmd_byte); end
        nlog++;
        pcode = (ncmd == err_at) ? err_c : 0;
        ncmd++;
        pend = 1;
        dly = $urandom % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  function automatic int byte_at(input logic [31:0] a);
    logic [15:0] w;
    w = exp_mem[(a >> 1) & 32'hFFF];
    return a[0] ? int'(w[7:0]) : int'(w[15:8]);
  endfunction

  task automatic add(input int op, input int b, inout int n, inout int e);
    e_op[ne] = op; e_b[ne] = b; ne++;
    if (n == err_at) e = err_c;
    n++;
  endtask

  task automatic predict();
    int p, n, e, len;
    logic [15:0] c;
    logic [31:0] bp;
    bit first;
    for (int i = 0; i < 4096; i++) exp_mem[i] = mem[i];
    ne = 0; etxb = 0; etxe = 0; p = int'(ring_base); first = 1; n = 0;
    for (int s = 0; s < 32; s++) begin
      c = exp_mem[p];
      if (!c[15]) break;
      len = int'(exp_mem[p+1]);
      bp = {exp_mem[p+2], exp_mem[p+3]};
      e = 0;
      if (first || c[10]) add(0, 0, n, e);
      for (int i = 0; i < len && e == 0; i++) add(1, byte_at(bp + 32'(i)), n, e);
      if (e == 0 && c[11]) add(2, 0, n, e);
      exp_mem[p] = {2'b00, c[13:10], 7'd0, e == 1, e == 3, e == 2};
      if (c[12]) begin if (e != 0) etxe++; else etxb++; end
      if (e != 0) break;
      p = c[13] ? int'(ring_base) : p + 4;
      first = 0;
    end
  endtask

  task automatic put_desc(input int a, input logic [15:0] c, input int len, input int bp);
    mem[a] = c; mem[a+1] = 16'(len); mem[a+2] = 16'(bp >> 16); mem[a+3] = 16'(bp);
  endtask

  task automatic clear_ring();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run_case(input string name);
    int t;
    bit bad;
    int bi;
    predict();
    nlog = 0; ncmd = 0; nwr = 0; nwatch = 0; ntxb = 0; ntxe = 0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy, {name, " R2 returns idle"}, int'(busy), 0);
    bad = (nlog != ne); bi = -1;
    for (int i = 0; i < ne && !bad; i++)
      if (log_op[i] != e_op[i] || (e_op[i] == 1 && log_b[i] != e_b[i])) begin bad = 1; bi = i; end
    chk(!bad, {name, " R4 command stream (count)"}, nlog, ne);
    if (bi >= 0) chk(0, {name, " R4 command op/byte at mismatch"}, log_op[bi]*256 + log_b[bi], e_op[bi]*256 + e_b[bi]);
    bad = 0; bi = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i] && !bad) begin bad = 1; bi = i; end
    chk(!bad, {name, " R7 descriptor write-back"}, int'(mem[bi]), int'(exp_mem[bi]));
    chk(ntxb == etxb && ntxe == etxe, {name, " R10 event counts"}, ntxb*100 + ntxe, etxb*100 + etxe);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4096; i++) mem[i] = 16'($urandom);
    clear_ring();
    watch = -1;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !mem_wr && !mem_rd && !ev_txb && !ev_txe, "R2 quiet in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid, "R2 idle after reset", int'(busy), 0);

    // not ready first descriptor
    ring_base = 12'd8;
    put_desc(8, 16'h7C07, 3, 4100);
    run_case("notready");
    chk(nlog == 0 && nwr == 0, "R2 not-ready entry untouched", nlog + nwr, 0);

    // forced start, start bit, stop bit (R3, R5)
    clear_ring(); ring_base = 12'd16;
    put_desc(16, 16'h8000, 2, 4200);
    put_desc(20, 16'h8C00, 1, 4301);
    run_case("frames");
    chk(nlog == 6 && log_op[0] == 0, "R3 forced start on first entry", log_op[0], 0);
    chk(nlog == 6 && log_op[2] == 1 && log_op[3] == 0, "R3 start from start bit", log_op[3], 0);
    chk(nlog == 6 && log_op[5] == 2, "R5 stop after last byte", log_op[5], 2);
    chk(log_b[1] == int'(mem[2100][15:8]) && log_b[4] == int'(mem[2150][7:0]), "R4 byte lane order", log_b[4], int'(mem[2150][7:0]));

    // zero length (R6)
    clear_ring(); ring_base = 12'd32;
    put_desc(32, 16'h9C00, 0, 4000);
    run_case("zerolen");
    chk(nlog == 2 && log_op[0] == 0 && log_op[1] == 2, "R6 zero length start+stop only", nlog, 2);
    chk(ntxb == 1, "R6 zero length completes", ntxb, 1);

    // wrap (R8)
    clear_ring(); ring_base = 12'd40; watch = 40;
    put_desc(40, 16'h8000, 1, 4400);
    put_desc(44, 16'hA000, 1, 4401);
    put_desc(48, 16'h8C00, 1, 4402);
    run_case("wrap");
    chk(nwatch == 2, "R8 wrap re-reads ring base", nwatch, 2);
    chk(mem[48] == 16'h8C00, "R8 entry after wrap not consumed", int'(mem[48]), 'h8C00);
    watch = -1;

    // errors (R9)
    for (int c = 1; c <= 3; c++) begin
      clear_ring(); ring_base = 12'd64;
      put_desc(64, 16'h9800, 3, 4500);
      put_desc(68, 16'h8C00, 1, 4510);
      err_at = (c == 2) ? 0 : 2; err_c = c;
      run_case("error");
      chk(mem[64][2:0] == ((c == 1) ? 3'b100 : (c == 3) ? 3'b010 : 3'b001), "R9 status bit for code", int'(mem[64][2:0]), c);
      chk(nlog == ((c == 2) ? 1 : 3), "R9 abort without stop", nlog, (c == 2) ? 1 : 3);
      chk(mem[68] == 16'h8C00 && ntxe == 1, "R9 ring halts after error", int'(mem[68]), 'h8C00);
    end

    // random rings
    for (int k = 0; k < 40; k++) begin
      int n, b;
      logic [15:0] c;
      clear_ring();
      b = ($urandom % 32) * 4;
      ring_base = 12'(b);
      n = 1 + $urandom % 5;
      for (int d = 0; d < n; d++) begin
        c = 16'($urandom);
        c[15] = 1'b1;
        c[13] = (d == n-1) ? 1'($urandom % 2) : 1'b0;
        put_desc(b + 4*d, c, $urandom % 6, 4096 + $urandom % 3000);
      end
      c = 16'($urandom); c[15] = 1'b0;
      mem[b + 4*n] = c;
      if ($urandom % 3 == 0) begin err_at = $urandom % 8; err_c = 1 + $urandom % 3; end
      else begin err_at = -1; err_c = 0; end
      run_case("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule